// File: doc/BRIEF.md
# Double-Buffered Edge-Aligned PWM Timer

This block is a 16-bit up-counter that drives one edge-aligned PWM output. Software programs a period (modulo) and a duty threshold (compare) as pairs of byte writes over a simple byte-addressed register port. Each 16-bit value passes through a two-stage path. A byte-pair latch keeps the two halves together. A shadow buffer then holds the finished value until the counter wraps to zero. A new period or duty therefore never disturbs the PWM cycle that is already running.

A clock-select field in the control register starts and stops the counter. While the counter is stopped the output keeps its level. A debug input changes one rule: a control-register write made in debug mode throws away a modulo high byte that is still waiting for its low byte. A channel flag marks compare matches. Software clears it by reading the flag as 1 and then writing 0 to it.

Each byte-pair latch is a two-state machine. In LATCH_EMPTY, a high-byte write goes to LATCH_HIGH. In LATCH_HIGH, a low-byte write commits the pair and returns to LATCH_EMPTY, and a debug clear also returns to LATCH_EMPTY. The flag is a three-state machine. FLAG_CLEAR goes to FLAG_SET on a match. FLAG_SET goes to FLAG_ARMED on a read of the channel register. FLAG_ARMED returns to FLAG_CLEAR on a write with bit 7 = 0, unless a match happens in the same cycle, in which case it goes to FLAG_SET.

Top module: `edge_pwm_timer`

Register map (address: content):
- 0: control. Bits [1:0] are the clock select: 00 stops the counter, any other value runs it.
- 1 and 2: modulo high and low byte.
- 3: channel control. Bit 7 is the flag. Bits [3:2] = 10 select edge PWM. Bit 0 = 1 selects low-true output.
- 4 and 5: compare high and low byte.
- 6 and 7: counter high and low byte, read only.

Reads of addresses 1, 2, 4 and 5 return the active values.

## Requirements
- R1: While the clock runs, the counter steps 0, 1, ..., modulo and then returns to 0, so the period is modulo+1 cycles.
- R2: With clock select 00, the counter holds its value and the output holds its level, even when the channel control register is written.
- R3: In edge-PWM mode with high-true output, the output is asserted in exactly the counts below the compare value. A compare of 0 gives no asserted count, and a compare above the modulo gives a fully asserted period. Low-true output is the inverse.
- R4: A new compare value takes effect only when the counter wraps to 0. The period in progress ends with the old duty, and this includes a change from non-zero to zero.
- R5: A modulo value is committed only by a high-byte write followed by a low-byte write. A lone high byte or a lone low byte leaves the period unchanged. A committed value takes effect at the next wrap.
- R6: A control write made while debug mode is set discards a pending modulo high byte. A control write made outside debug mode keeps it.
- R7: The channel flag (port and register bit 7) sets on a compare match while running. It clears only when a 0 is written to bit 7 after the flag was read as 1.
- R8: When the channel mode bits [3:2] are not 10, the output is driven low.
- R9: Reset leaves the counter, modulo, compare and clock select at 0, the latches empty, the flag clear and the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| dbg_mode | input | 1 | Debug mode: a control write clears the modulo byte latch |
| pwm_out | output | 1 | PWM output |
| chan_flag | output | 1 | Channel compare flag |

## Verification
The bench builds the block with the default 16-bit counter but uses only moduli from 0 to 7. This makes the duty sweep exhaustive: every compare value from 0 to 9 is tried against every such modulo in both polarities. That covers zero duty, full duty and the one-count period. Because the periods are short, the bench can line up byte writes with exact counter phases. It can also watch a whole old period and the new period after a mid-period duty change, a half-written modulo, or a debug control write.

// File: rtl/ept_pkg.sv
package ept_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_MOD_HI = 3'd1;
    localparam logic [2:0] A_MOD_LO = 3'd2;
    localparam logic [2:0] A_CHCTL  = 3'd3;
    localparam logic [2:0] A_CMP_HI = 3'd4;
    localparam logic [2:0] A_CMP_LO = 3'd5;
    localparam logic [2:0] A_CNT_HI = 3'd6;
    localparam logic [2:0] A_CNT_LO = 3'd7;

    localparam logic [1:0] MODE_EDGE = 2'b10;

    typedef enum logic {
        LATCH_EMPTY,
        LATCH_HIGH
    } latch_st_t;

    typedef enum logic [1:0] {
        FLAG_CLEAR,
        FLAG_SET,
        FLAG_ARMED
    } flag_st_t;
endpackage

// File: rtl/ept_pair_latch.sv
module ept_pair_latch
    import ept_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [W/2-1:0] din,
    input  logic           clr,
    input  logic           load,
    output logic [W-1:0]   act_q,
    output logic [W-1:0]   act_nxt
);
    localparam int HW = W / 2;

    latch_st_t      st_q, st_d;
    logic [HW-1:0]  hi_q;
    logic [W-1:0]   buf_q;
    logic           full_q;
    logic           commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LATCH_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LATCH_EMPTY: if (wr_hi) st_d = LATCH_HIGH;
            LATCH_HIGH: begin
                if (clr)        st_d = LATCH_EMPTY;
                else if (wr_lo) st_d = LATCH_EMPTY;
            end
            default: st_d = LATCH_EMPTY;
        endcase
    end

    assign commit  = (st_q == LATCH_HIGH) && wr_lo && !clr;
    assign act_nxt = (load && full_q) ? buf_q : act_q;

    // data outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            act_q  <= '0;
        end else begin
            if (wr_hi) hi_q <= din;
            if (commit) buf_q <= {hi_q, din};
            if (load && full_q) act_q <= buf_q;
            if (commit)    full_q <= 1'b1;
            else if (load) full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ept_counter.sv
module ept_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] mod_act,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    logic at_top;

    assign at_top  = (cnt_q == mod_act);
    assign cnt_nxt = at_top ? '0 : cnt_q + 1'b1;
    assign wrap    = run && at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/ept_channel.sv
module ept_channel
    import ept_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp_act,
    input  logic [W-1:0] cmp_nxt,
    input  logic         edge_en,
    input  logic         low_true,
    input  logic         rd_ctl,
    input  logic         wr_ctl,
    input  logic         wr_flag_bit,
    output logic         pwm_q,
    output logic         flag
);
    flag_st_t fst_q, fst_d;
    logic     match;

    assign match = run && (cnt_q == cmp_act);

    // flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst_q <= FLAG_CLEAR;
        else        fst_q <= fst_d;
    end

    // flag next state
    always_comb begin
        fst_d = fst_q;
        unique case (fst_q)
            FLAG_CLEAR: if (match) fst_d = FLAG_SET;
            FLAG_SET:   if (rd_ctl) fst_d = FLAG_ARMED;
            FLAG_ARMED: begin
                if (match)                     fst_d = FLAG_SET;
                else if (wr_ctl && !wr_flag_bit) fst_d = FLAG_CLEAR;
            end
            default: fst_d = FLAG_CLEAR;
        endcase
    end

    assign flag = (fst_q != FLAG_CLEAR);

    // output register: level for the coming count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pwm_q <= 1'b0;
        else if (run) pwm_q <= edge_en ? (low_true ^ (cnt_nxt < cmp_nxt)) : 1'b0;
    end
endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer
    import ept_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       dbg_mode,
    output logic       pwm_out,
    output logic       chan_flag
);
    localparam int HW = CNT_W / 2;

    logic [1:0]       clk_sel;
    logic [1:0]       ctl_mode;
    logic             ctl_lowtrue;
    logic             run, edge_en;
    logic             wr_ctrl, wr_chctl;
    logic [CNT_W-1:0] mod_act, mod_nxt, cmp_act, cmp_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             wrap;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_chctl = wr_en && (addr == A_CHCTL);
    assign run      = (clk_sel != 2'b00);
    assign edge_en  = (ctl_mode == MODE_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel     <= 2'b00;
            ctl_mode    <= 2'b00;
            ctl_lowtrue <= 1'b0;
        end else begin
            if (wr_ctrl) clk_sel <= wdata[1:0];
            if (wr_chctl) begin
                ctl_mode    <= wdata[3:2];
                ctl_lowtrue <= wdata[0];
            end
        end
    end

    ept_pair_latch #(.W(CNT_W)) u_mod (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi  (wr_en && (addr == A_MOD_HI)),
        .wr_lo  (wr_en && (addr == A_MOD_LO)),
        .din    (wdata[HW-1:0]),
        .clr    (wr_ctrl && dbg_mode),
        .load   (wrap),
        .act_q  (mod_act),
        .act_nxt(mod_nxt)
    );

    ept_pair_latch #(.W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi  (wr_en && (addr == A_CMP_HI)),
        .wr_lo  (wr_en && (addr == A_CMP_LO)),
        .din    (wdata[HW-1:0]),
        .clr    (1'b0),
        .load   (wrap),
        .act_q  (cmp_act),
        .act_nxt(cmp_nxt)
    );

    ept_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .mod_act(mod_act),
        .cnt_q  (cnt),
        .cnt_nxt(cnt_nxt),
        .wrap   (wrap)
    );

    ept_channel #(.W(CNT_W)) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt_q      (cnt),
        .cnt_nxt    (cnt_nxt),
        .cmp_act    (cmp_act),
        .cmp_nxt    (cmp_nxt),
        .edge_en    (edge_en),
        .low_true   (ctl_lowtrue),
        .rd_ctl     (rd_en && (addr == A_CHCTL)),
        .wr_ctl     (wr_chctl),
        .wr_flag_bit(wdata[7]),
        .pwm_q      (pwm_out),
        .flag       (chan_flag)
    );

    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {6'b0, clk_sel};
            A_MOD_HI: rdata = mod_act[CNT_W-1:HW];
            A_MOD_LO: rdata = mod_act[HW-1:0];
            A_CHCTL:  rdata = {chan_flag, 3'b0, ctl_mode, 1'b0, ctl_lowtrue};
            A_CMP_HI: rdata = cmp_act[CNT_W-1:HW];
            A_CMP_LO: rdata = cmp_act[HW-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:HW];
            default:  rdata = cnt[HW-1:0];
        endcase
    end
endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         edge_en,
    input logic         low_true,
    input logic [W-1:0] cnt,
    input logic [W-1:0] mod_act,
    input logic [W-1:0] cmp_act,
    input logic         pwm_out,
    input logic         chan_flag
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mod_act); // R1

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == mod_act) |=> (cnt == '0)); // R1

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(cnt) && $stable(pwm_out))); // R2

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_en && cnt != mod_act && cmp_act > mod_act)
        |=> (pwm_out == !$past(low_true))); // R3

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && edge_en && cnt != mod_act && cmp_act == '0)
        |=> (pwm_out == $past(low_true))); // R3

    AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act) |-> (cnt == '0)); // R4

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == cmp_act) |=> chan_flag); // R7
endmodule

bind edge_pwm_timer ept_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .edge_en  (edge_en),
    .low_true (ctl_lowtrue),
    .cnt      (cnt),
    .mod_act  (mod_act),
    .cmp_act  (cmp_act),
    .pwm_out  (pwm_out),
    .chan_flag(chan_flag)
);

// File: tb/sim_edge_pwm_timer.sv
`timescale 1ns/1ps
module sim_edge_pwm_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, dbg_mode = 1'b0;
    logic [2:0] addr = 3'd7;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out, chan_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dbg_mode(dbg_mode),
        .pwm_out(pwm_out), .chan_flag(chan_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd7;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 3'd7;
    endtask

    // stop at a negedge where the counter low byte reads 0
    task automatic sync0();
        addr = 3'd7;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rdata == 8'd0) break;
        end
    endtask

    task automatic measure_period(output int n);
        sync0();
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            n++;
            if (rdata == 8'd0) break;
        end
    endtask

    // count asserted cycles over len samples from a period start
    task automatic count_high(input int len, output int h);
        h = 0;
        for (int k = 0; k < len; k++) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] v;
        int h, p, exp;
        logic lvl;
        logic [7:0] c0;

        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R9 pwm after reset", pwm_out, 0);
        check(chan_flag == 1'b0, "R9 flag after reset", chan_flag, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rdata == 8'd0, "R9 count stays 0", rdata, 0);
        rd(3'd2, v);
        check(v == 8'd0, "R9 modulo 0", v, 0);
        rd(3'd0, v);
        check(v == 8'd0, "R9 clock select 00", v, 0);

        // exhaustive duty sweep, R1 and R3
        wr(3'd0, 8'h01);
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 10; c++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    wr(3'd1, 8'h00); wr(3'd2, 8'(m));
                    wr(3'd4, 8'h00); wr(3'd5, 8'(c));
                    wr(3'd3, 8'h08 | 8'(pol));
                    repeat (12) @(negedge clk);
                    sync0();
                    count_high(m + 1, h);
                    exp = (c < m + 1) ? c : m + 1;
                    if (pol == 1) exp = m + 1 - exp;
                    check(h == exp, $sformatf("R3 m=%0d c=%0d pol=%0d", m, c, pol), h, exp);
                    check(rdata == 8'd0, $sformatf("R1 period m=%0d", m), rdata, 0);
                end
            end
        end

        // R4: mid-period change to zero duty, then back up
        wr(3'd1, 8'h00); wr(3'd2, 8'd7);
        wr(3'd4, 8'h00); wr(3'd5, 8'd5); wr(3'd3, 8'h08);
        repeat (20) @(negedge clk);
        for (int step = 0; step < 2; step++) begin
            sync0();
            h = 0;
            for (int k = 0; k < 8; k++) begin
                if (pwm_out) h++;
                if (k == 0) begin addr = 3'd4; wdata = 8'h00; wr_en = 1'b1; end
                if (k == 1) begin addr = 3'd5; wdata = (step == 0) ? 8'd0 : 8'd3; end
                if (k == 2) begin wr_en = 1'b0; addr = 3'd7; end
                @(negedge clk);
            end
            exp = (step == 0) ? 5 : 0;
            check(h == exp, "R4 old duty finishes period", h, exp);
            count_high(8, h);
            exp = (step == 0) ? 0 : 3;
            check(h == exp, "R4 new duty from next period", h, exp);
        end

        // R5: modulo byte pairing
        wr(3'd1, 8'h00);
        repeat (20) @(negedge clk);
        measure_period(p);
        check(p == 8, "R5 lone high byte ignored", p, 8);
        wr(3'd2, 8'd3);
        repeat (20) @(negedge clk);
        measure_period(p);
        check(p == 4, "R5 pair committed", p, 4);
        wr(3'd2, 8'd5);
        repeat (20) @(negedge clk);
        measure_period(p);
        check(p == 4, "R5 lone low byte ignored", p, 4);

        // R6: debug control write discards pending high byte
        wr(3'd1, 8'h00);
        dbg_mode = 1'b1; wr(3'd0, 8'h01); dbg_mode = 1'b0;
        wr(3'd2, 8'd5);
        repeat (20) @(negedge clk);
        measure_period(p);
        check(p == 4, "R6 debug write cleared latch", p, 4);
        wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'd5);
        repeat (20) @(negedge clk);
        measure_period(p);
        check(p == 6, "R6 normal write keeps latch", p, 6);

        // R7: flag set, clear protocol
        check(chan_flag == 1'b1, "R7 flag set by match", chan_flag, 1);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h08);
        check(chan_flag == 1'b1, "R7 write 0 without read keeps flag", chan_flag, 1);
        rd(3'd3, v);
        check(v[7] == 1'b1, "R7 register bit 7 reads 1", v[7], 1);
        wr(3'd3, 8'h08);
        check(chan_flag == 1'b0, "R7 read then write 0 clears", chan_flag, 0);

        // R2: stopped counter and frozen output
        @(negedge clk);
        c0 = rdata; lvl = pwm_out;
        repeat (20) @(negedge clk);
        check(rdata == c0, "R2 count held", rdata, c0);
        wr(3'd3, 8'h09);
        repeat (5) @(negedge clk);
        check(pwm_out == lvl, "R2 output frozen after channel write", pwm_out, lvl);
        check(rdata == c0, "R2 count held after channel write", rdata, c0);
        wr(3'd0, 8'h01);
        repeat (2) @(negedge clk);
        check(rdata != c0, "R2 count resumes", rdata, c0 + 1);

        // R8: non-PWM mode drives low
        wr(3'd3, 8'h01);
        repeat (4) @(negedge clk);
        count_high(16, h);
        check(h == 0, "R8 output low outside edge mode", h, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule